// File: doc/BRIEF.md
# Byte-Lane Asynchronous SRAM Controller

This block sits between a synchronous host request port and an asynchronous static RAM built from four byte-wide lanes. The four lanes share one lane address bus and one active-low output enable. Each lane has its own active-low select and its own active-low write strobe. A static mode input arranges the same four lanes in one of three ways: one 32-bit bank, two 16-bit banks, or four 8-bit banks. For each request the controller decodes the host address and byte enables into lane selects and lane write strobes.

Every strobe is timed with clock-cycle counts. Each count is the matching nanosecond minimum divided by the `CLK_PERIOD_NS` parameter and rounded up. A write runs through an address setup phase, a strobe phase and a hold phase. A read holds select and output enable low for the access time and then captures the returned data. After every read the controller waits in a turnaround phase, so that its own data drivers never overlap data driven by the memory.

The host issues a request with a valid/ready handshake. A read answers with a one-cycle response pulse. In the narrow modes the read data is aligned to bit 0 and zero-extended.

Top module: `sram_lane_ctrl`

## Requirements
- R1: After reset, every lane select, every lane write strobe and the output enable are high. The data drivers are off, `reqReady` is 1 and `rspValid` is 0.
- R2: Mode 0 (word) selects all four lanes for every request and puts host address bits [19:2] on the lane address. A write pulls low the write strobe of lane i only when byte enable i is 1, which gives byte, half-word and word writes. A read returns all 32 bits, with lane i on bits [8i+7:8i].
- R3: Mode 1 (half-word): host address bit 19 picks the bank. Bank 0 is lanes 1:0 and bank 1 is lanes 3:2. Host address bits [18:1] form the lane address. Write data bits [15:0] and byte enables [1:0] map onto the low and high lane of the chosen bank. A read returns the bank's 16 bits, zero-extended.
- R4: Mode 2, and also the unused code 3 (byte): host address bits [19:18] pick the lane and bits [17:0] form the lane address. Byte enable 0 gates the write strobe. Write data bits [7:0] go to the chosen lane. A read returns that lane's byte, zero-extended.
- R5: A lane that the current mode and bank do not use keeps its select and its write strobe high for the whole request.
- R6: The output enable stays high while any write strobe is low. A write strobe is low only while its lane select is low. Every write strobe pulse lasts exactly STROBE_CYC cycles, which is the largest rounded-up count of the select-to-end (12 ns), data-setup (8 ns) and address-to-end (11 ns) minimums. At 10 ns this is 2 cycles.
- R7: Lane address and write data do not change while any lane select is low.
- R8: A read holds select and output enable low for READ_CYC cycles, the largest rounded-up count of the read cycle (20 ns), address access (20 ns) and output-enable access (9 ns) minimums. At 10 ns this is 2 cycles. The data is captured at the end of that window and `rspValid` is high for exactly one cycle.
- R9: The data drivers are never on while the output enable is low. They turn on no sooner than TURN_CYC+1 cycles after the output enable rises, where TURN_CYC is the rounded-up output-disable time (9 ns), at least 1.
- R10: `reqReady` is high only when no select and no output enable is active. A write produces no response pulse.
- R11: A write keeps its selects low for SETUP_CYC + STROBE_CYC + HOLD_CYC cycles, each phase at least 1 cycle. The hold phase is stretched if needed so that the total covers the 20 ns write cycle. At 10 ns the total is 4 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| cfgMode | input | 2 | Lane arrangement: 0 word, 1 half-word, 2 or 3 byte |
| reqValid | input | 1 | Host request valid |
| reqReady | output | 1 | Controller can accept a request |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | LANE_AW+2 | Host byte address |
| reqByteEn | input | 4 | Host byte enables |
| reqWdata | input | 32 | Host write data |
| rspValid | output | 1 | One-cycle read response strobe |
| rspData | output | 32 | Read data, aligned to bit 0 |
| ramAddr | output | LANE_AW | Shared lane address |
| ramCsN | output | 4 | Per-lane select, active low |
| ramWeN | output | 4 | Per-lane write strobe, active low |
| ramOeN | output | 1 | Shared output enable, active low |
| ramDout | output | 32 | Data toward the memory |
| ramDoutEn | output | 1 | Enable for the controller's data drivers |
| ramDin | input | 32 | Data returned by the memory |

## Verification
The bench targets the following corner cases.
- A read followed at once by a write. If the turnaround phase were dropped, the drivers would switch on one cycle after the output enable rose and the measured gap would fail.
- Partial byte-enable writes in word and half-word mode, and a byte-mode write with its enable cleared. A wrong lane mapping corrupts a neighbouring lane, which later read-backs expose as a wrong byte. The same errors also show up as a wrong select or strobe mask on an unused lane.
- Strobe and select widths, measured per request. A miscounted rounding shortens the write pulse or the read window.
- Narrow-mode reads. A misplaced bank bit or a missing zero-extension returns the wrong half or garbage in the upper bits.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;

  typedef enum logic [1:0] {
    MODE_WORD = 2'd0,
    MODE_HALF = 2'd1,
    MODE_BYTE = 2'd2
  } laneMode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_STROBE,
    ST_HOLD,
    ST_TURN
  } ctrlState_e;

  // Control-to-datapath strobe bundle
  typedef struct packed {
    logic latchReq;  // capture host request fields
    logic selOn;     // lane selects active
    logic weOn;      // write strobes active
    logic oeOn;      // output enable active
    logic drvOn;     // controller drives the data bus
    logic capture;   // sample memory read data
  } strobe_t;

  function automatic int cdiv(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_lane_fsm.sv
module sram_lane_fsm
  import sram_lane_pkg::*;
#(
  parameter int SETUP_CYC  = 1,
  parameter int STROBE_CYC = 2,
  parameter int HOLD_CYC   = 1,
  parameter int READ_CYC   = 2,
  parameter int TURN_CYC   = 1
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    reqWrite,
  output logic    reqReady,
  output strobe_t strb
);

  localparam int MAX_CYC = imax(imax(SETUP_CYC, STROBE_CYC),
                                imax(imax(HOLD_CYC, READ_CYC), TURN_CYC));
  localparam int CW = $clog2(MAX_CYC + 1);

  ctrlState_e      state;
  logic [CW-1:0]   cnt;
  logic            isWrite;
  logic            cntDone;

  assign cntDone = (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      isWrite <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (reqValid) begin
            isWrite <= reqWrite;
            if (reqWrite) begin
              state <= ST_SETUP;
              cnt   <= CW'(SETUP_CYC - 1);
            end else begin
              state <= ST_STROBE;
              cnt   <= CW'(READ_CYC - 1);
            end
          end
        end
        ST_SETUP: begin
          if (cntDone) begin
            state <= ST_STROBE;
            cnt   <= CW'(STROBE_CYC - 1);
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_STROBE: begin
          if (cntDone) begin
            if (isWrite) begin
              state <= ST_HOLD;
              cnt   <= CW'(HOLD_CYC - 1);
            end else begin
              state <= ST_TURN;
              cnt   <= CW'(TURN_CYC - 1);
            end
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_HOLD, ST_TURN: begin
          if (cntDone) state <= ST_IDLE;
          else         cnt   <= cnt - 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  logic busyWr;
  assign busyWr = (state == ST_SETUP) || (state == ST_STROBE && isWrite) || (state == ST_HOLD);

  always_comb begin
    reqReady      = (state == ST_IDLE);
    strb.latchReq = (state == ST_IDLE) && reqValid;
    strb.selOn    = busyWr || (state == ST_STROBE);
    strb.weOn     = (state == ST_STROBE) && isWrite;
    strb.oeOn     = (state == ST_STROBE) && !isWrite;
    strb.drvOn    = busyWr;
    strb.capture  = (state == ST_STROBE) && !isWrite && cntDone;
  end

endmodule

// File: rtl/sram_lane_dp.sv
module sram_lane_dp
  import sram_lane_pkg::*;
#(
  parameter int LANE_AW = 18
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [1:0]           cfgMode,
  input  logic [LANE_AW+1:0]   reqAddr,
  input  logic [3:0]           reqByteEn,
  input  logic [31:0]          reqWdata,
  input  strobe_t              strb,
  output logic                 rspValid,
  output logic [31:0]          rspData,
  output logic [LANE_AW-1:0]   ramAddr,
  output logic [3:0]           ramCsN,
  output logic [3:0]           ramWeN,
  output logic                 ramOeN,
  output logic [31:0]          ramDout,
  output logic                 ramDoutEn,
  input  logic [31:0]          ramDin
);

  localparam int LANES  = 4;
  localparam int LANE_W = 8;
  localparam int HAW    = LANE_AW + 2;

  // Request decode
  logic [LANES-1:0]   selD, weD;
  logic [LANE_AW-1:0] addrD;
  logic [1:0]         bankD;
  logic [31:0]        dataD;

  always_comb begin
    case (laneMode_e'(cfgMode))
      MODE_WORD: begin
        bankD = 2'd0;
        selD  = 4'b1111;
        weD   = reqByteEn;
        addrD = reqAddr[HAW-1:2];
        dataD = reqWdata;
      end
      MODE_HALF: begin
        bankD = {1'b0, reqAddr[HAW-1]};
        selD  = bankD[0] ? 4'b1100 : 4'b0011;
        weD   = bankD[0] ? {reqByteEn[1:0], 2'b00} : {2'b00, reqByteEn[1:0]};
        addrD = reqAddr[HAW-2:1];
        dataD = {2{reqWdata[15:0]}};
      end
      default: begin
        bankD = reqAddr[HAW-1:HAW-2];
        selD  = 4'b0001 << bankD;
        weD   = reqByteEn[0] ? selD : 4'b0000;
        addrD = reqAddr[LANE_AW-1:0];
        dataD = {LANES{reqWdata[7:0]}};
      end
    endcase
  end

  // Latched request
  laneMode_e          modeQ;
  logic [1:0]         bankQ;
  logic [LANES-1:0]   selQ, weQ;
  logic [LANE_AW-1:0] addrQ;
  logic [31:0]        dataQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ <= MODE_WORD;
      bankQ <= '0;
      selQ  <= '0;
      weQ   <= '0;
      addrQ <= '0;
      dataQ <= '0;
    end else if (strb.latchReq) begin
      modeQ <= (cfgMode == 2'd3) ? MODE_BYTE : laneMode_e'(cfgMode);
      bankQ <= bankD;
      selQ  <= selD;
      weQ   <= weD;
      addrQ <= addrD;
      dataQ <= dataD;
    end
  end

  // Per-lane pin drive
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign ramCsN[g] = ~(strb.selOn & selQ[g]);
    assign ramWeN[g] = ~(strb.weOn  & weQ[g]);
  end

  assign ramOeN    = ~strb.oeOn;
  assign ramDoutEn = strb.drvOn;
  assign ramDout   = dataQ;
  assign ramAddr   = addrQ;

  // Read data alignment
  logic [31:0] rdAligned;
  always_comb begin
    case (modeQ)
      MODE_WORD: rdAligned = ramDin;
      MODE_HALF: rdAligned = bankQ[0] ? {16'h0, ramDin[31:16]} : {16'h0, ramDin[15:0]};
      default:   rdAligned = {24'h0, ramDin[bankQ*LANE_W +: LANE_W]};
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspData  <= '0;
    end else begin
      rspValid <= strb.capture;
      if (strb.capture) rspData <= rdAligned;
    end
  end

endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
  import sram_lane_pkg::*;
#(
  parameter int CLK_PERIOD_NS = 10,
  parameter int LANE_AW       = 18,
  parameter int T_WR_CYCLE    = 20,
  parameter int T_ADDR_SETUP  = 2,
  parameter int T_ADDR_TO_END = 11,
  parameter int T_DATA_SETUP  = 8,
  parameter int T_SEL_TO_END  = 12,
  parameter int T_DATA_HOLD   = 1,
  parameter int T_RD_CYCLE    = 20,
  parameter int T_ADDR_ACCESS = 20,
  parameter int T_OE_ACCESS   = 9,
  parameter int T_OE_HIZ      = 9
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [1:0]         cfgMode,
  input  logic               reqValid,
  output logic               reqReady,
  input  logic               reqWrite,
  input  logic [LANE_AW+1:0] reqAddr,
  input  logic [3:0]         reqByteEn,
  input  logic [31:0]        reqWdata,
  output logic               rspValid,
  output logic [31:0]        rspData,
  output logic [LANE_AW-1:0] ramAddr,
  output logic [3:0]         ramCsN,
  output logic [3:0]         ramWeN,
  output logic               ramOeN,
  output logic [31:0]        ramDout,
  output logic               ramDoutEn,
  input  logic [31:0]        ramDin
);

  localparam int SETUP_CYC  = imax(1, cdiv(T_ADDR_SETUP, CLK_PERIOD_NS));
  localparam int STROBE_CYC = imax(1, imax(cdiv(T_SEL_TO_END, CLK_PERIOD_NS),
                                   imax(cdiv(T_DATA_SETUP, CLK_PERIOD_NS),
                                        cdiv(T_ADDR_TO_END, CLK_PERIOD_NS))));
  localparam int HOLD_CYC   = imax(1, imax(cdiv(T_DATA_HOLD, CLK_PERIOD_NS),
                                   cdiv(T_WR_CYCLE, CLK_PERIOD_NS) - SETUP_CYC - STROBE_CYC));
  localparam int READ_CYC   = imax(1, imax(cdiv(T_RD_CYCLE, CLK_PERIOD_NS),
                                   imax(cdiv(T_ADDR_ACCESS, CLK_PERIOD_NS),
                                        cdiv(T_OE_ACCESS, CLK_PERIOD_NS))));
  localparam int TURN_CYC   = imax(1, cdiv(T_OE_HIZ, CLK_PERIOD_NS));

  strobe_t strb;

  sram_lane_fsm #(
    .SETUP_CYC (SETUP_CYC),
    .STROBE_CYC(STROBE_CYC),
    .HOLD_CYC  (HOLD_CYC),
    .READ_CYC  (READ_CYC),
    .TURN_CYC  (TURN_CYC)
  ) u_fsm (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .reqWrite(reqWrite),
    .reqReady(reqReady),
    .strb    (strb)
  );

  sram_lane_dp #(
    .LANE_AW(LANE_AW)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .cfgMode  (cfgMode),
    .reqAddr  (reqAddr),
    .reqByteEn(reqByteEn),
    .reqWdata (reqWdata),
    .strb     (strb),
    .rspValid (rspValid),
    .rspData  (rspData),
    .ramAddr  (ramAddr),
    .ramCsN   (ramCsN),
    .ramWeN   (ramWeN),
    .ramOeN   (ramOeN),
    .ramDout  (ramDout),
    .ramDoutEn(ramDoutEn),
    .ramDin   (ramDin)
  );

endmodule

// File: rtl/sram_lane_chk.sv
module sram_lane_chk #(
  parameter int LANE_AW    = 18,
  parameter int STROBE_CYC = 2,
  parameter int TURN_CYC   = 1
) (
  input logic               clk,
  input logic               rstN,
  input logic               reqReady,
  input logic               rspValid,
  input logic [LANE_AW-1:0] ramAddr,
  input logic [3:0]         ramCsN,
  input logic [3:0]         ramWeN,
  input logic               ramOeN,
  input logic [31:0]        ramDout,
  input logic               ramDoutEn
);

  logic [7:0] weRun;
  logic [7:0] oeGap;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      weRun <= '0;
      oeGap <= 8'hFF;
    end else begin
      weRun <= (ramWeN != 4'hF) ? weRun + 8'd1 : 8'd0;
      if (!ramOeN)             oeGap <= 8'd0;
      else if (oeGap != 8'hFF) oeGap <= oeGap + 8'd1;
    end
  end

  p_oe_high_in_write_r6: assert property (@(posedge clk) disable iff (!rstN)
    (ramWeN != 4'hF) |-> ramOeN);

  p_we_inside_cs_r6: assert property (@(posedge clk) disable iff (!rstN)
    (ramWeN != 4'hF) |-> ((~ramWeN & ramCsN) == 4'h0));

  p_we_width_r6: assert property (@(posedge clk) disable iff (!rstN)
    (ramWeN == 4'hF && weRun != 8'd0) |-> (weRun == 8'(STROBE_CYC)));

  p_addr_data_stable_r7: assert property (@(posedge clk) disable iff (!rstN)
    (ramCsN != 4'hF && $past(ramCsN != 4'hF)) |-> ($stable(ramAddr) && $stable(ramDout)));

  p_rsp_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);

  p_no_drive_on_read_r9: assert property (@(posedge clk) disable iff (!rstN)
    ramDoutEn |-> ramOeN);

  p_turn_gap_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ramDoutEn) |-> (oeGap > 8'(TURN_CYC)));

  p_ready_idle_r10: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (ramCsN == 4'hF && ramOeN));

endmodule

bind sram_lane_ctrl sram_lane_chk #(
  .LANE_AW   (LANE_AW),
  .STROBE_CYC(STROBE_CYC),
  .TURN_CYC  (TURN_CYC)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .reqReady (reqReady),
  .rspValid (rspValid),
  .ramAddr  (ramAddr),
  .ramCsN   (ramCsN),
  .ramWeN   (ramWeN),
  .ramOeN   (ramOeN),
  .ramDout  (ramDout),
  .ramDoutEn(ramDoutEn)
);

// File: tb/test_sram_lane_ctrl.sv
module test_sram_lane_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int LANE_AW    = 18;
  localparam int WE_CYC     = 2;  // ceil(12/10)
  localparam int WR_CYC     = 4;  // 1 setup + 2 strobe + 1 hold
  localparam int RD_CYC     = 2;  // ceil(20/10)
  localparam int TURN_CYC   = 1;  // ceil(9/10)
  localparam int NVEC       = 15;

  typedef struct packed {
    logic [1:0]  mode;
    logic        wr;
    logic [19:0] addr;
    logic [3:0]  be;
    logic [31:0] wd;
    logic [3:0]  csM;
    logic [3:0]  weM;
    logic [31:0] rd;
  } vec_t;

  localparam vec_t VEC [NVEC] = '{
    '{2'd0, 1'b1, 20'h00010, 4'hF, 32'h11223344, 4'hF, 4'hF, 32'h0},
    '{2'd0, 1'b0, 20'h00010, 4'h0, 32'h0,        4'hF, 4'h0, 32'h11223344},
    '{2'd0, 1'b1, 20'h00010, 4'h5, 32'hAABBCCDD, 4'hF, 4'h5, 32'h0},
    '{2'd0, 1'b0, 20'h00010, 4'h0, 32'h0,        4'hF, 4'h0, 32'h11BB33DD},
    '{2'd1, 1'b1, 20'h80008, 4'h3, 32'h0000BEEF, 4'hC, 4'hC, 32'h0},
    '{2'd1, 1'b0, 20'h80008, 4'h0, 32'h0,        4'hC, 4'h0, 32'h0000BEEF},
    '{2'd1, 1'b0, 20'h00008, 4'h0, 32'h0,        4'h3, 4'h0, 32'h000033DD},
    '{2'd1, 1'b1, 20'h00008, 4'h2, 32'h00007700, 4'h3, 4'h2, 32'h0},
    '{2'd1, 1'b0, 20'h00008, 4'h0, 32'h0,        4'h3, 4'h0, 32'h000077DD},
    '{2'd2, 1'b1, 20'hC0004, 4'h1, 32'h0000005A, 4'h8, 4'h8, 32'h0},
    '{2'd2, 1'b0, 20'hC0004, 4'h0, 32'h0,        4'h8, 4'h0, 32'h0000005A},
    '{2'd2, 1'b0, 20'h40004, 4'h0, 32'h0,        4'h2, 4'h0, 32'h00000077},
    '{2'd2, 1'b1, 20'h00004, 4'h0, 32'h00000099, 4'h1, 4'h0, 32'h0},
    '{2'd2, 1'b0, 20'h00004, 4'h0, 32'h0,        4'h1, 4'h0, 32'h000000DD},
    '{2'd0, 1'b0, 20'h00010, 4'h0, 32'h0,        4'hF, 4'h0, 32'h5AEF77DD}
  };

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic [1:0]         cfgMode = 2'd0;
  logic               reqValid = 1'b0;
  logic               reqReady;
  logic               reqWrite = 1'b0;
  logic [LANE_AW+1:0] reqAddr = '0;
  logic [3:0]         reqByteEn = '0;
  logic [31:0]        reqWdata = '0;
  logic               rspValid;
  logic [31:0]        rspData;
  logic [LANE_AW-1:0] ramAddr;
  logic [3:0]         ramCsN, ramWeN;
  logic               ramOeN;
  logic [31:0]        ramDout;
  logic               ramDoutEn;
  logic [31:0]        ramDin;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sram_lane_ctrl i_sram_lane_ctrl (
    .clk(clk), .rstN(rstN), .cfgMode(cfgMode),
    .reqValid(reqValid), .reqReady(reqReady), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqByteEn(reqByteEn), .reqWdata(reqWdata),
    .rspValid(rspValid), .rspData(rspData),
    .ramAddr(ramAddr), .ramCsN(ramCsN), .ramWeN(ramWeN), .ramOeN(ramOeN),
    .ramDout(ramDout), .ramDoutEn(ramDoutEn), .ramDin(ramDin)
  );

  // Behavioural four-lane memory model (small, aliased on low address bits)
  logic [7:0] mem [4][64];
  logic [3:0] prevWeN = 4'hF;

  initial begin
    for (int l = 0; l < 4; l++)
      for (int a = 0; a < 64; a++) mem[l][a] = 8'h00;
  end

  always @(negedge clk) begin
    for (int l = 0; l < 4; l++) begin
      if (!prevWeN[l] && ramWeN[l] && ramDoutEn)
        mem[l][ramAddr[5:0]] = ramDout[l*8 +: 8];
    end
    prevWeN = ramWeN;
  end

  always_comb begin
    for (int l = 0; l < 4; l++)
      ramDin[l*8 +: 8] = (!ramCsN[l] && ramWeN[l] && !ramOeN) ? mem[l][ramAddr[5:0]] : 8'h00;
  end

  task automatic chk(input string tag, input string what, input bit ok,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic string modeTag(input logic [1:0] m);
    case (m)
      2'd0:    return "R2";
      2'd1:    return "R3";
      default: return "R4";
    endcase
  endfunction

  // Global monitors
  int   contention = 0;
  int   busyReady  = 0;
  int   lastOeRise = -1000;
  int   minGap     = 1000;
  logic prevOe     = 1'b1;
  logic prevDrv    = 1'b0;

  task automatic runVec(input vec_t v);
    logic [3:0]         csM = 4'h0, weM = 4'h0;
    int                 weLow = 0, csLow = 0, oeLow = 0, rspCnt = 0, unstable = 0;
    logic [31:0]        rd = '0;
    logic [LANE_AW-1:0] aSeen = '0;
    logic [31:0]        dSeen = '0;
    bit                 haveA = 0, haveD = 0;
    int                 n = 0;
    string              tag = modeTag(v.mode);

    cfgMode = v.mode;
    while (!reqReady) @(negedge clk);
    reqValid  = 1'b1;
    reqWrite  = v.wr;
    reqAddr   = v.addr;
    reqByteEn = v.be;
    reqWdata  = v.wd;
    @(negedge clk);
    reqValid = 1'b0;
    forever begin
      csM |= ~ramCsN;
      weM |= ~ramWeN;
      if (ramWeN != 4'hF) weLow++;
      if (ramCsN != 4'hF) begin
        csLow++;
        if (haveA && ramAddr != aSeen) unstable++;
        aSeen = ramAddr; haveA = 1;
      end
      if (ramDoutEn) begin
        if (haveD && ramDout != dSeen) unstable++;
        dSeen = ramDout; haveD = 1;
      end
      if (!ramOeN) oeLow++;
      if (rspValid) begin rspCnt++; rd = rspData; end
      if (ramDoutEn && !ramOeN) contention++;
      if (reqReady && (ramCsN != 4'hF || !ramOeN)) busyReady++;
      if (!prevOe && ramOeN) lastOeRise = cyc;
      if (!prevDrv && ramDoutEn && (cyc - lastOeRise) < minGap) minGap = cyc - lastOeRise;
      prevOe  = ramOeN;
      prevDrv = ramDoutEn;
      if (reqReady) break;
      n++;
      if (n > 50) begin
        chk(tag, "request never completed", 1'b0, 32'(n), 32'd0);
        break;
      end
      @(negedge clk);
    end

    chk(tag, "select mask", csM == v.csM, 32'(csM), 32'(v.csM));
    chk("R5", "unused lanes idle (select)", (csM & ~v.csM) == 4'h0, 32'(csM), 32'(v.csM));
    chk(tag, "write strobe mask", weM == v.weM, 32'(weM), 32'(v.weM));
    chk("R7", "address/data stable under select", unstable == 0, 32'(unstable), 32'd0);
    if (v.wr) begin
      chk("R6", "write strobe cycles", weLow == ((v.weM != 4'h0) ? WE_CYC : 0),
          32'(weLow), 32'((v.weM != 4'h0) ? WE_CYC : 0));
      chk("R11", "write select cycles", csLow == WR_CYC, 32'(csLow), 32'(WR_CYC));
      chk("R10", "no response on write", rspCnt == 0, 32'(rspCnt), 32'd0);
    end else begin
      chk("R8", "read select cycles", csLow == RD_CYC, 32'(csLow), 32'(RD_CYC));
      chk("R8", "read output enable cycles", oeLow == RD_CYC, 32'(oeLow), 32'(RD_CYC));
      chk("R8", "one response pulse", rspCnt == 1, 32'(rspCnt), 32'd1);
      chk(tag, "read data", rd == v.rd, rd, v.rd);
    end
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 20000);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=%0d expected=done", cyc);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    repeat (4) @(negedge clk);
    // R1: reset state, sampled while reset is held and just after release
    chk("R1", "selects high in reset", ramCsN == 4'hF, 32'(ramCsN), 32'hF);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1", "selects high", ramCsN == 4'hF, 32'(ramCsN), 32'hF);
    chk("R1", "write strobes high", ramWeN == 4'hF, 32'(ramWeN), 32'hF);
    chk("R1", "output enable high", ramOeN == 1'b1, 32'(ramOeN), 32'd1);
    chk("R1", "drivers off", ramDoutEn == 1'b0, 32'(ramDoutEn), 32'd0);
    chk("R1", "ready", reqReady == 1'b1, 32'(reqReady), 32'd1);
    chk("R1", "no response", rspValid == 1'b0, 32'(rspValid), 32'd0);

    for (int i = 0; i < NVEC; i++) runVec(VEC[i]);

    // Mode code 3 behaves as byte mode (R4): read lane 3 back
    runVec('{2'd3, 1'b0, 20'hC0004, 4'h0, 32'h0, 4'h8, 4'h0, 32'h0000005A});

    // Read immediately followed by write exercises the turnaround (R9)
    runVec('{2'd0, 1'b0, 20'h00010, 4'h0, 32'h0, 4'hF, 4'h0, 32'h5AEF77DD});
    runVec('{2'd0, 1'b1, 20'h00010, 4'h8, 32'h01000000, 4'hF, 4'h8, 32'h0});
    runVec('{2'd0, 1'b0, 20'h00010, 4'h0, 32'h0, 4'hF, 4'h0, 32'h01EF77DD});

    chk("R9", "drivers never overlap output enable", contention == 0, 32'(contention), 32'd0);
    chk("R9", "turnaround gap", minGap >= TURN_CYC + 1, 32'(minGap), 32'(TURN_CYC + 1));
    chk("R10", "ready only when idle", busyReady == 0, 32'(busyReady), 32'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule